// File: doc/BRIEF.md
# PWM Channel with Latched Fault Shutdown

This block is a single pulse-width channel driven by a free-running period counter. Software programs a period value, a duty value and a 3-bit mode code over a small write-only register port. When the mode code is `3'b111`, the counter steps on each time-base tick. The pin value is high for the first part of every period and low for the rest.

An active-low fault input protects the load. A low level on it removes the output enable at once, through logic with no clock edge in the path, so the pin floats. A synchronized copy of the input latches a fault status bit and raises an interrupt flag. Both the latch and the disabled output stay in place until the fault input has gone high again and software has rewritten the PWM mode code. A new duty value waits in a buffer and takes effect only at a period boundary.

Top module: `pwm_fault_chan`

## Requirements
- R1: After reset, `pwm_out`, `pwm_oe`, `flt_sts`, `irq_flag` and `irq` are all 0.
- R2: Any mode code (address 0, bits [2:0]) other than `3'b111` keeps `pwm_out` and `pwm_oe` low and holds the counter at 0. While the channel is in such a mode, a low fault input does not set the fault latch.
- R3: A period value N (address 1) gives a period of N+1 ticks. The count runs 0..N, then returns to 0. The count also returns to 0 if it is found at or above N after the period value is lowered.
- R4: `pwm_out` is high while the count is below the active duty value and low otherwise. A duty of 0 gives a constant low. A duty above the period value gives a constant high.
- R5: A duty write (address 2) goes to a buffer. The active duty takes the buffer value only when the count wraps, or while the channel is not in PWM mode.
- R6: While `fault_n` is low, `pwm_oe` is 0 without waiting for any clock edge.
- R7: `fault_n` passes through a two-flop synchronizer. When the fault input is low before edge k, `flt_sts` is 1 after edge k+2 while in PWM mode.
- R8: Once set, `flt_sts` stays 1 and `pwm_oe` stays 0 until a write of `3'b111` to the mode field happens while the synchronized fault input is high. Releasing the fault alone does not clear the latch, and neither does the rewrite alone.
- R9: Address 3 is the interrupt control: bit 0 is the enable and bit 1 is the flag. Setting the fault latch sets `irq_flag`. Writing 0 to bit 1 clears the flag, and writing 1 to it has no effect. `irq` equals `irq_flag` AND the enable.
- R10: The counter advances only on clock edges where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base enable from a fixed divider |
| fault_n | input | 1 | Asynchronous fault input, low means fault |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 mode, 1 period, 2 duty, 3 interrupt control |
| wr_data | input | W | Write data |
| pwm_out | output | 1 | PWM pin value |
| pwm_oe | output | 1 | Pin output enable; 0 leaves the pin at high impedance |
| flt_sts | output | 1 | Read-only latched fault status |
| irq_flag | output | 1 | Channel interrupt flag |
| irq | output | 1 | Interrupt request (flag gated by enable) |

## Verification
A wrong count or a wrong active duty shows up on `pwm_out` within one period. If the duty buffer loads early, the pulse width changes before the wrap. A fault latch stuck high or cleared early shows up as a wrong `pwm_oe` and `flt_sts` on the first cycle after the release or the rewrite. A broken synchronizer shifts the rise of `flt_sts` and `irq_flag` by a cycle. Every output is compared on every cycle against an independent model, so each of these errors is reported in the cycle it first appears.

// File: rtl/pwm_fault_chan.sv
module pwm_fault_chan #(
  parameter int W = 16,
  parameter logic [2:0] PWM_CODE = 3'b111
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         fault_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic         pwm_out,
  output logic         pwm_oe,
  output logic         flt_sts,
  output logic         irq_flag,
  output logic         irq
);

  localparam logic [1:0] A_MODE = 2'd0;
  localparam logic [1:0] A_PER  = 2'd1;
  localparam logic [1:0] A_DUTY = 2'd2;
  localparam logic [1:0] A_CTL  = 2'd3;

  logic [2:0]   mode;
  logic [W-1:0] per, dbuf, dact, cnt;
  logic         fs1, fs2, flt_q, flag_q, ie_q;
  logic         run, wrap, flt_set, rearm, flag_clr;

  assign run      = (mode == PWM_CODE);
  assign wrap     = run && tick && (cnt >= per);
  assign flt_set  = run && !fs2;
  assign rearm    = wr_en && (wr_addr == A_MODE) && (wr_data[2:0] == PWM_CODE) && fs2;
  assign flag_clr = wr_en && (wr_addr == A_CTL) && !wr_data[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0;
      per  <= '0;
      dbuf <= '0;
      ie_q <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_MODE:  mode <= wr_data[2:0];
        A_PER:   per  <= wr_data;
        A_DUTY:  dbuf <= wr_data;
        default: ie_q <= wr_data[0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      dact <= '0;
    end else if (!run) begin
      cnt  <= '0;
      dact <= dbuf;
    end else if (wrap) begin
      cnt  <= '0;
      dact <= dbuf;
    end else if (tick) begin
      cnt  <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs1    <= 1'b1;
      fs2    <= 1'b1;
      flt_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      fs1 <= fault_n;
      fs2 <= fs1;
      if (flt_set)    flt_q <= 1'b1;
      else if (rearm) flt_q <= 1'b0;
      if (flt_set && !flt_q) flag_q <= 1'b1;
      else if (flag_clr)     flag_q <= 1'b0;
    end
  end

  assign pwm_out  = run && (cnt < dact);
  assign pwm_oe   = run && !flt_q && fault_n;
  assign flt_sts  = flt_q;
  assign irq_flag = flag_q;
  assign irq      = flag_q && ie_q;

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && cnt >= per && mode == $past(mode)) |=> (cnt == '0)); // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (run -> $stable(cnt))); // R10
  AST_DUTY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(tick && cnt >= per)) |=> $stable(dact)); // R5
  AST_LATCH_GATES_OE: assert property (@(posedge clk) disable iff (!rst_n)
    flt_q |-> !pwm_oe); // R8
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_q && !(wr_en && wr_addr == A_MODE)) |=> flt_q); // R8
  AST_CLEAR_NEEDS_REWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flt_q) |-> $past(wr_en && wr_addr == A_MODE && fs2)); // R8
  AST_FAULT_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_q) |-> irq_flag); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!pwm_out && !pwm_oe)); // R2

endmodule

// File: tb/test_pwm_fault_chan.sv
module test_pwm_fault_chan;
  localparam int W = 16;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n, tick, fault_n, wr_en;
  logic [1:0] wr_addr;
  logic [W-1:0] wr_data;
  logic pwm_out, pwm_oe, flt_sts, irq_flag, irq;

  always #(CLK_P/2) clk = ~clk;

  pwm_fault_chan #(.W(W)) i_pwm_fault_chan (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fault_n(fault_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe), .flt_sts(flt_sts),
    .irq_flag(irq_flag), .irq(irq));

  typedef struct {
    logic  out;
    logic  oe;
    logic  sts;
    logic  irq;
    logic  flag;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t mon_e;
  int checks = 0;
  int errors = 0;

  logic [2:0]   m_mode;
  logic [W-1:0] m_per, m_buf, m_duty, m_cnt;
  logic         m_s1, m_s2, m_flt, m_flag, m_ie;

  task automatic chk(input logic ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  always begin
    @(posedge clk);
    #(CLK_P/4);
    if (exp_q.size() > 0) begin
      mon_e = exp_q.pop_front();
      chk({pwm_out, pwm_oe, flt_sts, irq} == {mon_e.out, mon_e.oe, mon_e.sts, mon_e.irq},
          mon_e.tag, {pwm_out, pwm_oe, flt_sts, irq}, {mon_e.out, mon_e.oe, mon_e.sts, mon_e.irq});
      chk(irq_flag == mon_e.flag, mon_e.tag, {3'b0, irq_flag}, {3'b0, mon_e.flag});
    end
  end

  task automatic cyc(input logic we, input logic [1:0] a, input logic [W-1:0] d,
                     input logic fn, input logic tk, input string tag);
    exp_t e;
    logic run_o, set_c, clr_c;
    wr_en = we; wr_addr = a; wr_data = d; fault_n = fn; tick = tk;
    run_o = (m_mode == 3'b111);
    set_c = run_o && !m_s2;
    clr_c = we && a == 2'd0 && d[2:0] == 3'b111 && m_s2;
    if (!run_o) begin
      m_cnt = '0; m_duty = m_buf;
    end else if (tk) begin
      if (m_cnt >= m_per) begin m_cnt = '0; m_duty = m_buf; end
      else m_cnt = m_cnt + 1'b1;
    end
    if (set_c && !m_flt) m_flag = 1'b1;
    else if (we && a == 2'd3 && !d[1]) m_flag = 1'b0;
    if (set_c) m_flt = 1'b1;
    else if (clr_c) m_flt = 1'b0;
    m_s2 = m_s1; m_s1 = fn;
    if (we) begin
      case (a)
        2'd0: m_mode = d[2:0];
        2'd1: m_per = d;
        2'd2: m_buf = d;
        default: m_ie = d[0];
      endcase
    end
    e.out  = (m_mode == 3'b111) && (m_cnt < m_duty);
    e.oe   = (m_mode == 3'b111) && !m_flt && fn;
    e.sts  = m_flt;
    e.irq  = m_flag && m_ie;
    e.flag = m_flag;
    e.tag  = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic fn, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, '0, fn, 1'b1, tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; fault_n = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    m_mode = '0; m_per = '0; m_buf = '0; m_duty = '0; m_cnt = '0;
    m_s1 = 1'b1; m_s2 = 1'b1; m_flt = 1'b0; m_flag = 1'b0; m_ie = 1'b0;
    repeat (3) @(negedge clk);
    chk({pwm_out, pwm_oe, flt_sts, irq} == 4'b0000, "R1", {pwm_out, pwm_oe, flt_sts, irq}, 4'b0000);
    rst_n = 1'b1;
    idle(2, 1'b1, "R1");

    // R2: non-PWM mode stays quiet
    cyc(1'b1, 2'd1, 16'd7, 1'b1, 1'b1, "R3");
    cyc(1'b1, 2'd2, 16'd3, 1'b1, 1'b1, "R4");
    cyc(1'b1, 2'd0, 16'd2, 1'b1, 1'b1, "R2");
    idle(4, 1'b1, "R2");

    // R3 / R4: period 8, duty 3
    cyc(1'b1, 2'd0, 16'd7, 1'b1, 1'b1, "R3");
    idle(20, 1'b1, "R3");

    // R5: duty change mid period
    idle(3, 1'b1, "R5");
    cyc(1'b1, 2'd2, 16'd5, 1'b1, 1'b1, "R5");
    idle(18, 1'b1, "R5");

    // R4: duty extremes
    cyc(1'b1, 2'd2, 16'd0, 1'b1, 1'b1, "R4");
    idle(18, 1'b1, "R4");
    cyc(1'b1, 2'd2, 16'd9, 1'b1, 1'b1, "R4");
    idle(18, 1'b1, "R4");

    // R3: shorter period written while count is above it
    cyc(1'b1, 2'd1, 16'd3, 1'b1, 1'b1, "R3");
    cyc(1'b1, 2'd2, 16'd2, 1'b1, 1'b1, "R3");
    idle(14, 1'b1, "R3");

    // R10: tick gating
    for (int i = 0; i < 16; i++) cyc(1'b0, 2'd0, '0, 1'b1, (i % 3) == 0, "R10");

    // R9: enable interrupt
    cyc(1'b1, 2'd3, 16'd1, 1'b1, 1'b1, "R9");

    // R6: immediate shutdown, no clock edge
    fault_n = 1'b0;
    #1;
    chk(pwm_oe == 1'b0, "R6", {3'b0, pwm_oe}, 4'b0000);
    idle(5, 1'b0, "R7");

    // R8: rewrite while fault still low keeps latch
    cyc(1'b1, 2'd0, 16'd7, 1'b0, 1'b1, "R8");
    idle(3, 1'b0, "R8");
    // R8: release alone keeps latch
    idle(4, 1'b1, "R8");
    // R8: release plus rewrite restores
    cyc(1'b1, 2'd0, 16'd7, 1'b1, 1'b1, "R8");
    idle(6, 1'b1, "R8");

    // R9: writing 1 to flag bit keeps it, writing 0 clears
    cyc(1'b1, 2'd3, 16'd3, 1'b1, 1'b1, "R9");
    idle(2, 1'b1, "R9");
    cyc(1'b1, 2'd3, 16'd1, 1'b1, 1'b1, "R9");
    idle(2, 1'b1, "R9");

    // R2: fault while not in PWM mode does not latch
    cyc(1'b1, 2'd0, 16'd0, 1'b1, 1'b1, "R2");
    idle(5, 1'b0, "R2");
    idle(3, 1'b1, "R2");

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule